// File: doc/BRIEF.md
# Display Controller Register-Script Sequencer

This block configures a TFT panel controller through its serial control port. It works without software. A fixed table of register writes sits in on-chip ROM. Each step in the table holds an 8-bit register number, a 16-bit value and a wait time in milliseconds. After reset the block plays the initialisation script. It then plays a short script that hands pixel transfer over to the parallel RGB path. After that it waits for changes on a single power-request level and plays the power-down or power-up script that matches.

Each step turns into two serial frames of three bytes each:

- A select frame, which names the register.
- A value frame, which carries the 16-bit word.

After the value frame the block waits for the step's delay. The millisecond base comes from a divider on the system clock, and its division ratio is a parameter. The serial clock half-period is also a parameter.

Top module: `lcd_script_seq`

## Requirements
- R1: The first frame of every step is three bytes: 0x70, then 0x00, then the register number.
- R2: The second frame of every step is three bytes: 0x72, then the value's upper byte, then its lower byte.
- R3: Frames use SPI mode 0 and are sent most significant bit first. Chip-select is low for exactly 24 clock pulses per frame and goes high between frames. The serial clock is low whenever chip-select is high. Frames never overlap.
- R4: After a step's value frame, the next select frame waits for that step's delay times TICK_DIV cycles. A zero delay adds no wait.
- R5: After reset the block plays the 47-step init script and then the 4-step RGB hand-over script. The init script includes waits of 200 ms after register 0x13, and 50 ms after registers 0x12 and 0x29. It ends with 0x0133 to register 0x07. The hand-over script writes 0x1080 to 0x03, 0x0000 to 0x20 and 0x0000 to 0x21, then 0x0111 to 0x0C followed by 500 ms. `busy` stays high from reset until the hand-over script ends.
- R6: `done` pulses high for one cycle when the boot sequence ends and when each power script ends. It is never high while `busy` is high.
- R7: The power-down script writes register 0x07 with 0x0131 (then 100 ms), 0x0130 (then 100 ms) and 0x0100. It then writes 0x0280 to 0x10 and 0x018B to 0x12.
- R8: The power-up script writes 0x1280 to 0x10. It then writes register 0x07 with 0x0101, 0x0121, 0x0123 and 0x0133, followed by waits of 100, 0, 100 and 10 ms.
- R9: `pwr_req` uses 1 for on and 0 for off. The power state is on after boot. A request level equal to the current state causes no serial traffic.
- R10: A change of `pwr_req` while a script runs is acted on once that script has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_req | input | 1 | Requested panel power level (1 on, 0 off), synchronous to clk |
| spi_cs_n | output | 1 | Serial chip-select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| busy | output | 1 | A script is being played |
| done | output | 1 | One-cycle pulse at the end of a script run |

## Verification
The assertions take `pwr_req` to be synchronous to `clk` and free to change at any time, including mid-script. They take reset to be held for at least one edge before the first check. The stimulus changes `pwr_req` only from tasks between clock edges. It holds the level high throughout boot, so the first power action is a deliberate power-down. It then flips the level while the power-up script is running, which tests how a request that arrives mid-script is held until the script ends.

// File: rtl/lcd_seq_pkg.sv
// Shared types and the script ROM for the display register-script sequencer.
// Assumes: all scripts together fit in 2**ROM_AW steps; waits fit in MS_W bits.
package lcd_seq_pkg;

    localparam int ROM_AW = 6;
    localparam int MS_W   = 10;
    localparam int FRM_W  = 24;

    localparam logic [7:0] SEL_HDR = 8'h70;
    localparam logic [7:0] VAL_HDR = 8'h72;

    // Script placement inside the ROM (first and last step of each)
    localparam logic [ROM_AW-1:0] INIT_FIRST = 6'd0;
    localparam logic [ROM_AW-1:0] INIT_FINAL = 6'd46;
    localparam logic [ROM_AW-1:0] RGB_FIRST  = 6'd47;
    localparam logic [ROM_AW-1:0] RGB_FINAL  = 6'd50;
    localparam logic [ROM_AW-1:0] DOWN_FIRST = 6'd51;
    localparam logic [ROM_AW-1:0] DOWN_FINAL = 6'd55;
    localparam logic [ROM_AW-1:0] UP_FIRST   = 6'd56;
    localparam logic [ROM_AW-1:0] UP_FINAL   = 6'd60;

    typedef struct packed {
        logic [7:0]      regno;
        logic [15:0]     word;
        logic [MS_W-1:0] wait_ms;
    } step_t;

    typedef enum logic [1:0] {TX_IDLE, TX_LOW, TX_HIGH, TX_GAP} tx_state_t;

    typedef enum logic [2:0] {
        SQ_BOOT, SQ_SEL, SQ_SEL_W, SQ_VAL, SQ_VAL_W, SQ_WAIT, SQ_NEXT, SQ_IDLE
    } sq_state_t;

    // Script ROM: one step per address, {register, value, wait}
    function automatic step_t step_at(input logic [ROM_AW-1:0] a);
        step_t s;
        case (a)
            6'd0:  s = {8'h01, 16'h0000, 10'd0};
            6'd1:  s = {8'h02, 16'h0700, 10'd0};
            6'd2:  s = {8'h03, 16'h50A0, 10'd0};
            6'd3:  s = {8'h04, 16'h0000, 10'd0};
            6'd4:  s = {8'h08, 16'h0606, 10'd0};
            6'd5:  s = {8'h09, 16'h0000, 10'd0};
            6'd6:  s = {8'h0A, 16'h0000, 10'd0};
            6'd7:  s = {8'h0C, 16'h0000, 10'd0};
            6'd8:  s = {8'h0D, 16'h0000, 10'd0};
            6'd9:  s = {8'h0F, 16'h0002, 10'd0};
            6'd10: s = {8'h11, 16'h0007, 10'd0};
            6'd11: s = {8'h12, 16'h0000, 10'd0};
            6'd12: s = {8'h13, 16'h0000, 10'd200};
            6'd13: s = {8'h07, 16'h0101, 10'd0};
            6'd14: s = {8'h10, 16'h12B0, 10'd0};
            6'd15: s = {8'h11, 16'h0007, 10'd0};
            6'd16: s = {8'h12, 16'h01BB, 10'd50};
            6'd17: s = {8'h13, 16'h0013, 10'd0};
            6'd18: s = {8'h29, 16'h0010, 10'd50};
            6'd19: s = {8'h30, 16'h000A, 10'd0};
            6'd20: s = {8'h31, 16'h1326, 10'd0};
            6'd21: s = {8'h32, 16'h0A29, 10'd0};
            6'd22: s = {8'h35, 16'h0A0A, 10'd0};
            6'd23: s = {8'h36, 16'h1E03, 10'd0};
            6'd24: s = {8'h37, 16'h031E, 10'd0};
            6'd25: s = {8'h38, 16'h0706, 10'd0};
            6'd26: s = {8'h39, 16'h0303, 10'd0};
            6'd27: s = {8'h3C, 16'h010E, 10'd0};
            6'd28: s = {8'h3D, 16'h040E, 10'd0};
            6'd29: s = {8'h50, 16'h0000, 10'd0};
            6'd30: s = {8'h51, 16'h00EF, 10'd0};
            6'd31: s = {8'h52, 16'h0000, 10'd0};
            6'd32: s = {8'h53, 16'h013F, 10'd0};
            6'd33: s = {8'h60, 16'h2700, 10'd0};
            6'd34: s = {8'h61, 16'h0001, 10'd0};
            6'd35: s = {8'h6A, 16'h0000, 10'd0};
            6'd36: s = {8'h80, 16'h0000, 10'd0};
            6'd37: s = {8'h81, 16'h0000, 10'd0};
            6'd38: s = {8'h82, 16'h0000, 10'd0};
            6'd39: s = {8'h83, 16'h0000, 10'd0};
            6'd40: s = {8'h84, 16'h0000, 10'd0};
            6'd41: s = {8'h85, 16'h0000, 10'd0};
            6'd42: s = {8'h90, 16'h0010, 10'd0};
            6'd43: s = {8'h92, 16'h0000, 10'd0};
            6'd44: s = {8'h95, 16'h0210, 10'd0};
            6'd45: s = {8'h97, 16'h0000, 10'd0};
            6'd46: s = {8'h07, 16'h0133, 10'd0};
            6'd47: s = {8'h03, 16'h1080, 10'd0};
            6'd48: s = {8'h20, 16'h0000, 10'd0};
            6'd49: s = {8'h21, 16'h0000, 10'd0};
            6'd50: s = {8'h0C, 16'h0111, 10'd500};
            6'd51: s = {8'h07, 16'h0131, 10'd100};
            6'd52: s = {8'h07, 16'h0130, 10'd100};
            6'd53: s = {8'h07, 16'h0100, 10'd0};
            6'd54: s = {8'h10, 16'h0280, 10'd0};
            6'd55: s = {8'h12, 16'h018B, 10'd0};
            6'd56: s = {8'h10, 16'h1280, 10'd0};
            6'd57: s = {8'h07, 16'h0101, 10'd100};
            6'd58: s = {8'h07, 16'h0121, 10'd0};
            6'd59: s = {8'h07, 16'h0123, 10'd100};
            6'd60: s = {8'h07, 16'h0133, 10'd10};
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/lcd_seq_tick.sv
// Millisecond tick generator.
// Counts system clocks only while `run` is high and restarts from zero
// whenever `run` drops, so a wait of N ms lasts exactly N*TICK_DIV cycles.
// Assumes TICK_DIV >= 1.
module lcd_seq_tick #(
    parameter int TICK_DIV = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] TOP = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt;

    // Free-running divider while a wait is in progress
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == TOP) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == TOP);

    generate
        if (TICK_DIV > 1) begin : g_tick_chk
            // R4
            tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/lcd_seq_spi_tx.sv
// Serial frame transmitter, SPI mode 0, MSB first.
// A one-cycle `start` while `ready` loads a FRM_W-bit frame. Chip-select
// stays low for the whole frame and high for a HALF-cycle gap afterwards.
// Assumes `start` is only raised while `ready` is high.
module lcd_seq_spi_tx #(
    parameter int FRM_W = 24,
    parameter int HALF  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [FRM_W-1:0] frame,
    output logic             ready,
    output logic             cs_n,
    output logic             sclk,
    output logic             mosi
);
    import lcd_seq_pkg::*;

    localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BW = $clog2(FRM_W);
    localparam logic [DW-1:0] DTOP = DW'(HALF - 1);
    localparam logic [BW-1:0] BTOP = BW'(FRM_W - 1);

    tx_state_t        st;
    logic [DW-1:0]    div;
    logic [BW-1:0]    bits;
    logic [FRM_W-1:0] sh;

    // Bit-level shifter and serial clock generator
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= TX_IDLE;
            div  <= '0;
            bits <= '0;
            sh   <= '0;
            cs_n <= 1'b1;
            sclk <= 1'b0;
        end else begin
            case (st)
                TX_IDLE: begin
                    if (start) begin
                        sh   <= frame;
                        cs_n <= 1'b0;
                        bits <= '0;
                        div  <= '0;
                        st   <= TX_LOW;
                    end
                end
                TX_LOW: begin
                    if (div == DTOP) begin
                        div  <= '0;
                        sclk <= 1'b1;
                        st   <= TX_HIGH;
                    end else begin
                        div <= div + 1'b1;
                    end
                end
                TX_HIGH: begin
                    if (div == DTOP) begin
                        div  <= '0;
                        sclk <= 1'b0;
                        if (bits == BTOP) begin
                            cs_n <= 1'b1;
                            st   <= TX_GAP;
                        end else begin
                            bits <= bits + 1'b1;
                            sh   <= {sh[FRM_W-2:0], 1'b0};
                            st   <= TX_LOW;
                        end
                    end else begin
                        div <= div + 1'b1;
                    end
                end
                default: begin
                    if (div == DTOP) begin
                        div <= '0;
                        st  <= TX_IDLE;
                    end else begin
                        div <= div + 1'b1;
                    end
                end
            endcase
        end
    end

    assign ready = (st == TX_IDLE);
    assign mosi  = cs_n ? 1'b0 : sh[FRM_W-1];

    // R3
    idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    // R3
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));
    // R3
    cs_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> !cs_n);

endmodule

// File: rtl/lcd_seq_ctrl.sv
// Script player.
// Walks the ROM one step at a time: it sends the select frame, then the value
// frame, then waits for the step's delay. Boot plays the init script and then
// the RGB hand-over script. After that it compares the power request level
// with the stored power state whenever it is idle.
// Assumes pwr_req is synchronous to clk.
module lcd_seq_ctrl (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                pwr_req,
    input  logic                                tx_ready,
    input  logic                                tick,
    output logic                                tx_start,
    output logic [lcd_seq_pkg::FRM_W-1:0]       tx_frame,
    output logic                                tick_run,
    output logic                                busy,
    output logic                                done
);
    import lcd_seq_pkg::*;

    sq_state_t        st;
    logic [ROM_AW-1:0] addr;
    logic [ROM_AW-1:0] final_addr;
    logic              in_init;
    logic              boot_done;
    logic              pwr_on;
    logic [MS_W-1:0]   ms_left;
    step_t             cur;

    assign cur = step_at(addr);

    // Step sequencing, waits and power-request handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= SQ_BOOT;
            addr       <= INIT_FIRST;
            final_addr <= INIT_FINAL;
            in_init    <= 1'b1;
            boot_done  <= 1'b0;
            pwr_on     <= 1'b1;
            ms_left    <= '0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                SQ_BOOT: st <= SQ_SEL;
                SQ_SEL:  st <= SQ_SEL_W;
                SQ_SEL_W: if (tx_ready) st <= SQ_VAL;
                SQ_VAL:  st <= SQ_VAL_W;
                SQ_VAL_W: begin
                    if (tx_ready) begin
                        ms_left <= cur.wait_ms;
                        st      <= SQ_WAIT;
                    end
                end
                SQ_WAIT: begin
                    if (ms_left == '0) begin
                        st <= SQ_NEXT;
                    end else if (tick) begin
                        ms_left <= ms_left - 1'b1;
                    end
                end
                SQ_NEXT: begin
                    if (addr != final_addr) begin
                        addr <= addr + 1'b1;
                        st   <= SQ_SEL;
                    end else if (in_init) begin
                        in_init    <= 1'b0;
                        addr       <= RGB_FIRST;
                        final_addr <= RGB_FINAL;
                        st         <= SQ_SEL;
                    end else begin
                        boot_done <= 1'b1;
                        done      <= 1'b1;
                        st        <= SQ_IDLE;
                    end
                end
                default: begin
                    if (pwr_req != pwr_on) begin
                        pwr_on     <= pwr_req;
                        addr       <= pwr_req ? UP_FIRST : DOWN_FIRST;
                        final_addr <= pwr_req ? UP_FINAL : DOWN_FINAL;
                        st         <= SQ_SEL;
                    end
                end
            endcase
        end
    end

    // Frame selection for the transmitter
    always_comb begin
        tx_start = (st == SQ_SEL) || (st == SQ_VAL);
        if (st == SQ_VAL) begin
            tx_frame = {VAL_HDR, cur.word};
        end else begin
            tx_frame = {SEL_HDR, 8'h00, cur.regno};
        end
    end

    assign tick_run = (st == SQ_WAIT);
    assign busy     = (st != SQ_IDLE);

    // R3
    start_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> tx_ready);
    // R4
    wait_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_WAIT && $past(st) == SQ_WAIT) |-> (ms_left <= $past(ms_left)));
    // R5
    boot_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_done |-> busy);
    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R9
    ignore_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && pwr_req == pwr_on) |=> !busy);
    // R10
    hold_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(pwr_on) || $past(st) == SQ_IDLE);

endmodule

// File: rtl/lcd_script_seq.sv
// Top level of the display register-script sequencer.
// Ties the script player to the serial transmitter and the millisecond tick.
// Assumes TICK_DIV clock cycles make one millisecond and SCLK_HALF >= 1.
module lcd_script_seq #(
    parameter int TICK_DIV  = 100000,
    parameter int SCLK_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_req,
    output logic spi_cs_n,
    output logic spi_sclk,
    output logic spi_mosi,
    output logic busy,
    output logic done
);
    import lcd_seq_pkg::*;

    logic             tx_ready;
    logic             tx_start;
    logic [FRM_W-1:0] tx_frame;
    logic             tick;
    logic             tick_run;

    lcd_seq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_req  (pwr_req),
        .tx_ready (tx_ready),
        .tick     (tick),
        .tx_start (tx_start),
        .tx_frame (tx_frame),
        .tick_run (tick_run),
        .busy     (busy),
        .done     (done)
    );

    lcd_seq_spi_tx #(.FRM_W(FRM_W), .HALF(SCLK_HALF)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tx_start),
        .frame (tx_frame),
        .ready (tx_ready),
        .cs_n  (spi_cs_n),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi)
    );

    lcd_seq_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tick_run),
        .tick  (tick)
    );

endmodule

// File: tb/test_lcd_script_seq.sv
// Scoreboard bench: tasks queue expected frames, a monitor decodes the line.
module test_lcd_script_seq;
    localparam int TD   = 40;
    localparam int HALF = 2;
    localparam int SLACK = HALF + 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_req = 1'b1;
    logic spi_cs_n, spi_sclk, spi_mosi, busy, done;

    always #2 clk = ~clk;

    lcd_script_seq #(.TICK_DIV(TD), .SCLK_HALF(HALF)) i_lcd_script_seq (
        .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .busy(busy), .done(done)
    );

    typedef struct {
        logic [23:0] f;
        int          ms;
        bit          gchk;
        string       tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int frames_seen = 0;
    int done_rises = 0;
    int done_cycles = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected scripts: {register, value, wait_ms}
    function automatic logic [33:0] spec(input int a);
        case (a)
            0:  return {8'h01, 16'h0000, 10'd0};
            1:  return {8'h02, 16'h0700, 10'd0};
            2:  return {8'h03, 16'h50A0, 10'd0};
            3:  return {8'h04, 16'h0000, 10'd0};
            4:  return {8'h08, 16'h0606, 10'd0};
            5:  return {8'h09, 16'h0000, 10'd0};
            6:  return {8'h0A, 16'h0000, 10'd0};
            7:  return {8'h0C, 16'h0000, 10'd0};
            8:  return {8'h0D, 16'h0000, 10'd0};
            9:  return {8'h0F, 16'h0002, 10'd0};
            10: return {8'h11, 16'h0007, 10'd0};
            11: return {8'h12, 16'h0000, 10'd0};
            12: return {8'h13, 16'h0000, 10'd200};
            13: return {8'h07, 16'h0101, 10'd0};
            14: return {8'h10, 16'h12B0, 10'd0};
            15: return {8'h11, 16'h0007, 10'd0};
            16: return {8'h12, 16'h01BB, 10'd50};
            17: return {8'h13, 16'h0013, 10'd0};
            18: return {8'h29, 16'h0010, 10'd50};
            19: return {8'h30, 16'h000A, 10'd0};
            20: return {8'h31, 16'h1326, 10'd0};
            21: return {8'h32, 16'h0A29, 10'd0};
            22: return {8'h35, 16'h0A0A, 10'd0};
            23: return {8'h36, 16'h1E03, 10'd0};
            24: return {8'h37, 16'h031E, 10'd0};
            25: return {8'h38, 16'h0706, 10'd0};
            26: return {8'h39, 16'h0303, 10'd0};
            27: return {8'h3C, 16'h010E, 10'd0};
            28: return {8'h3D, 16'h040E, 10'd0};
            29: return {8'h50, 16'h0000, 10'd0};
            30: return {8'h51, 16'h00EF, 10'd0};
            31: return {8'h52, 16'h0000, 10'd0};
            32: return {8'h53, 16'h013F, 10'd0};
            33: return {8'h60, 16'h2700, 10'd0};
            34: return {8'h61, 16'h0001, 10'd0};
            35: return {8'h6A, 16'h0000, 10'd0};
            36: return {8'h80, 16'h0000, 10'd0};
            37: return {8'h81, 16'h0000, 10'd0};
            38: return {8'h82, 16'h0000, 10'd0};
            39: return {8'h83, 16'h0000, 10'd0};
            40: return {8'h84, 16'h0000, 10'd0};
            41: return {8'h85, 16'h0000, 10'd0};
            42: return {8'h90, 16'h0010, 10'd0};
            43: return {8'h92, 16'h0000, 10'd0};
            44: return {8'h95, 16'h0210, 10'd0};
            45: return {8'h97, 16'h0000, 10'd0};
            46: return {8'h07, 16'h0133, 10'd0};
            47: return {8'h03, 16'h1080, 10'd0};
            48: return {8'h20, 16'h0000, 10'd0};
            49: return {8'h21, 16'h0000, 10'd0};
            50: return {8'h0C, 16'h0111, 10'd500};
            51: return {8'h07, 16'h0131, 10'd100};
            52: return {8'h07, 16'h0130, 10'd100};
            53: return {8'h07, 16'h0100, 10'd0};
            54: return {8'h10, 16'h0280, 10'd0};
            55: return {8'h12, 16'h018B, 10'd0};
            56: return {8'h10, 16'h1280, 10'd0};
            57: return {8'h07, 16'h0101, 10'd100};
            58: return {8'h07, 16'h0121, 10'd0};
            59: return {8'h07, 16'h0123, 10'd100};
            60: return {8'h07, 16'h0133, 10'd10};
            default: return '0;
        endcase
    endfunction

    // Driver: queue the two frames of each step; R1 select, R2 value
    task automatic push_script(input int first, input int last,
                               input bit gap_after_last, input string tag);
        for (int a = first; a <= last; a++) begin
            logic [33:0] s;
            item_t it;
            s = spec(a);
            it.f = {8'h70, 8'h00, s[33:26]}; it.ms = 0; it.gchk = 1'b1;
            it.tag = {tag, "/R1"};
            q.push_back(it);
            it.f = {8'h72, s[25:10]}; it.ms = int'(s[9:0]);
            it.gchk = (a != last) || gap_after_last;
            it.tag = {tag, "/R2"};
            q.push_back(it);
        end
    endtask

    // Monitor: decode frames at the negative edge, check gaps (R3, R4)
    initial begin
        logic        p_cs, p_sclk, have_prev, prev_gchk;
        logic [23:0] shreg;
        int          nbits, t_end, prev_ms, gap;
        item_t       it;
        p_cs = 1'b1; p_sclk = 1'b0; have_prev = 1'b0; prev_gchk = 1'b0;
        shreg = '0; nbits = 0; t_end = 0; prev_ms = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (spi_cs_n && spi_sclk) chk(1'b0, "R3", "sclk high while idle", 1, 0);
                if (done) begin
                    done_cycles++;
                    if (busy) chk(1'b0, "R6", "done while busy", 1, 0);
                end
                if (p_cs && !spi_cs_n) begin
                    if (have_prev && prev_gchk) begin
                        gap = cyc - t_end;
                        chk(gap >= prev_ms * TD && gap <= prev_ms * TD + SLACK,
                            "R4", "gap cycles", gap, prev_ms * TD);
                    end
                    nbits = 0;
                end
                if (!p_sclk && spi_sclk && !spi_cs_n) begin
                    shreg = {shreg[22:0], spi_mosi};
                    nbits++;
                end
                if (!p_cs && spi_cs_n) begin
                    frames_seen++;
                    chk(nbits == 24, "R3", "clock pulses per frame", nbits, 24);
                    if (q.size() == 0) begin
                        chk(1'b0, "R9", "unexpected frame", shreg, 0);
                        have_prev = 1'b0;
                    end else begin
                        it = q.pop_front();
                        chk(shreg == it.f, it.tag, "frame", shreg, it.f);
                        have_prev = 1'b1;
                        prev_ms = it.ms;
                        prev_gchk = it.gchk;
                    end
                    t_end = cyc;
                end
            end
            p_cs = spi_cs_n;
            p_sclk = spi_sclk;
        end
    end

    always @(posedge done) done_rises++;

    task automatic wait_quiet;
        while (q.size() != 0 || busy) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        while (cyc < 190000) @(negedge clk);
        chk(1'b0, "WDOG", "run timed out", cyc, 190000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seen;
        repeat (5) @(negedge clk);
        chk(spi_cs_n === 1'b1, "R3", "cs_n in reset", spi_cs_n, 1);
        chk(spi_sclk === 1'b0, "R3", "sclk in reset", spi_sclk, 0);
        chk(busy === 1'b1, "R5", "busy in reset", busy, 1);
        push_script(0, 46, 1'b1, "R5 init");
        push_script(47, 50, 1'b0, "R5 rgb");
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b1, "R5", "busy after reset", busy, 1);
        while (busy) @(negedge clk);
        chk(q.size() == 0, "R5", "frames left at end of boot", q.size(), 0);
        chk(done_rises == 1, "R6", "done pulses after boot", done_rises, 1);
        chk(done_cycles == 1, "R6", "done width", done_cycles, 1);

        // R9: same level as the power state sends nothing
        seen = frames_seen;
        repeat (2000) @(negedge clk);
        chk(frames_seen == seen && !busy, "R9", "traffic on equal request", frames_seen - seen, 0);

        // R7: power down
        push_script(51, 55, 1'b0, "R7 down");
        pwr_req = 1'b0;
        wait_quiet();
        chk(q.size() == 0, "R7", "frames left", q.size(), 0);
        chk(done_rises == 2, "R6", "done pulses after down", done_rises, 2);

        // R10: request flips back during the power-up script
        push_script(56, 60, 1'b0, "R8 up");
        push_script(51, 55, 1'b0, "R10 down");
        pwr_req = 1'b1;
        while (frames_seen < seen + 14) @(negedge clk);
        pwr_req = 1'b0;
        wait_quiet();
        chk(q.size() == 0, "R10", "frames left", q.size(), 0);
        chk(done_rises == 4, "R10", "done pulses", done_rises, 4);

        // R8: power up again, then R9 once more
        push_script(56, 60, 1'b0, "R8 up2");
        pwr_req = 1'b1;
        wait_quiet();
        seen = frames_seen;
        repeat (1000) @(negedge clk);
        chk(frames_seen == seen, "R9", "traffic after up", frames_seen - seen, 0);
        chk(done_rises == 5 && done_cycles == 5, "R6", "done pulses total", done_cycles, 5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule